// File: doc/BRIEF.md
# Parallel Configuration Write Port

This block is the write-only parallel loading path of a programmable crosspoint switch. A host drives an operation code, a port/switch select bit, a row bus and a column bus, asserts a chip select and raises a strobe. Each qualified rising strobe edge becomes exactly one update. That update is either a crosspoint change in a square connection map or a write of an attribute value into one or more per-line port registers. Nothing in the block can be read back through this port. The connection map and the attribute registers are brought out as flat vectors for the switch fabric that uses them.

A two-bit mode register controls which updates are accepted. It holds an enable bit and a port-mode bit. At reset both bits take the value on a strap input. After reset a simple register-write port, which stands in for the serial scan path, can rewrite them. When the enable bit is low, no strobe has any effect. When the enable bit is high and the port-mode bit is low, the select bit is treated as low, so every cycle is a map operation. When both bits are high, a cycle can address either kind of target.

The strobe is asynchronous to the block clock, so it passes through a synchronizer and an edge detector. An update therefore reaches the outputs on the third rising clock edge after the strobe goes high.

Top module: `cfgw_top`

## Requirements
- R1: While reset is held, both mode bits equal the strap input, every map bit is 0 and every attribute register is 0.
- R2: One update is made per rising strobe edge seen with chip select high. Its effect appears on the outputs no later than the third rising clock edge after the strobe rises. A strobe edge seen with chip select low changes nothing.
- R3: With the effective select low, op code 0 sets map bit `xbar_map[row*LINES+col]` and op code 1 clears it.
- R4: With the effective select low, op code 2 clears every bit of the addressed row, leaving all other rows unchanged.
- R5: While the enable bit (`mode_state[1]`) is 0, strobes change neither the map nor the attributes, whatever the port-mode bit holds.
- R6: With enable 1 and port-mode (`mode_state[0]`) 0, the select input is treated as 0. Op code 3 does nothing, and op codes 0 to 2 act on the map even when the select input is 1.
- R7: With both mode bits set and the select input 1, op code 3 writes attributes and op codes 0 to 2 do nothing. With the select input 0, op code 3 does nothing.
- R8: In an attribute write, `row[ATTR_W-1:0]` is the value and `row[ATTR_W+2:ATTR_W]` is a group code g. The span is 2^min(g,4) lines, aligned on the span: every line whose index matches `col` once the low log2(span) bits are ignored is written. This covers 1, 2, 4, 8 or 16 lines in one cycle.
- R9: Map operations whose row, or whose column for op codes 0 and 1, is at or above LINES do nothing. An attribute group whose base is at or above LINES writes nothing.
- R10: A cycle with `mode_wr` high loads `mode_wdata` ({enable, port-mode}) into the mode register, and the value is visible on `mode_state` after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en | input | 1 | Strap value loaded into both mode bits at reset |
| mode_wr | input | 1 | Mode register write strobe (serial path stand-in) |
| mode_wdata | input | 2 | New mode value {enable, port-mode} |
| cfg_cs | input | 1 | Chip select for the parallel port |
| cfg_strobe | input | 1 | Write strobe; rising edge commits |
| cfg_ps | input | 1 | Port (1) / switch (0) select |
| cfg_op | input | 2 | Operation code: 0 set, 1 clear, 2 clear row, 3 attribute |
| cfg_row | input | ADDR_W | Row address, or attribute value and group code |
| cfg_col | input | ADDR_W | Column address, or attribute group base |
| xbar_map | output | LINES*LINES | Connection map, bit row*LINES+col |
| port_attr | output | LINES*ATTR_W | Attribute registers, line p at [p*ATTR_W +: ATTR_W] |
| mode_state | output | 2 | Current mode {enable, port-mode} |

## Verification
The assertions assume that the host holds chip select, select, op code, row and column steady from the rising strobe edge until the synchronized edge has been used. They also assume that the strobe stays at each level for at least two clock cycles, so that no edge is lost in the synchronizer. The bench drives the buses and raises the strobe together on a falling clock edge and keeps all of them steady for six cycles. It then lowers the strobe and waits three idle cycles before the next transfer. Mode writes are issued only between transfers, so the mode an update is judged under is always well defined.

// File: rtl/cfgw_pkg.sv
`timescale 1ns/1ps
package cfgw_pkg;
   typedef enum logic [1:0] {
      OP_SET    = 2'd0,
      OP_CLR    = 2'd1,
      OP_CLRROW = 2'd2,
      OP_ATTR   = 2'd3
   } cfg_op_e;

   typedef struct packed {
      logic en;
      logic pm;
   } mode_t;
endpackage

// File: rtl/cfgw_strobe_sync.sv
`timescale 1ns/1ps
module cfgw_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_in,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfgw_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], strobe_in};
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

   // R2: a single strobe edge yields a single update pulse
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/cfgw_ctrl.sv
`timescale 1ns/1ps
module cfgw_ctrl
   import cfgw_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        strap_en,
   input  logic        mode_wr,
   input  logic [1:0]  mode_wdata,
   input  logic        rise,
   input  logic        cs,
   input  logic        ps,
   input  logic [1:0]  op,
   output mode_t       mode_o,
   output logic        map_wr_o,
   output logic        attr_wr_o,
   output cfg_op_e     op_o
);
   mode_t mode_q;
   logic  ps_eff;
   logic  cmd_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q.en <= strap_en;
         mode_q.pm <= strap_en;
      end else if (mode_wr) begin
         mode_q.en <= mode_wdata[1];
         mode_q.pm <= mode_wdata[0];
      end
   end

   always_comb begin
      op_o      = cfg_op_e'(op);
      ps_eff    = ps & mode_q.pm;
      cmd_ok    = rise & cs & mode_q.en;
      map_wr_o  = cmd_ok & ~ps_eff & (op_o != OP_ATTR);
      attr_wr_o = cmd_ok & ps_eff & (op_o == OP_ATTR);
   end

   assign mode_o = mode_q;

   // R10: a mode write lands on the following edge
   a_r10_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (mode_q == $past(mode_wdata)));
endmodule

// File: rtl/cfgw_xbar_cells.sv
`timescale 1ns/1ps
module cfgw_xbar_cells
   import cfgw_pkg::*;
#(
   parameter int LINES  = 16,
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  cfg_op_e           op,
   input  logic [ADDR_W-1:0] row,
   input  logic [ADDR_W-1:0] col,
   output logic [LINES*LINES-1:0] map_o
);
   generate
      for (genvar r = 0; r < LINES; r++) begin : g_row
         logic             row_hit;
         logic [LINES-1:0] cells_q;

         assign row_hit = wr && (row == ADDR_W'(r));

         for (genvar c = 0; c < LINES; c++) begin : g_col
            logic col_hit;
            assign col_hit = (col == ADDR_W'(c));
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  cells_q[c] <= 1'b0;
               else if (row_hit) begin
                  if (op == OP_CLRROW)             cells_q[c] <= 1'b0;
                  else if (col_hit && op == OP_SET) cells_q[c] <= 1'b1;
                  else if (col_hit && op == OP_CLR) cells_q[c] <= 1'b0;
               end
            end
         end

         assign map_o[r*LINES +: LINES] = cells_q;

         // R4: clearing a row empties it
         a_r4_row_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (row_hit && op == OP_CLRROW) |=> (cells_q == '0));
      end
   endgenerate
endmodule

// File: rtl/cfgw_attr_bank.sv
`timescale 1ns/1ps
module cfgw_attr_bank #(
   parameter int LINES  = 16,
   parameter int ADDR_W = 9,
   parameter int ATTR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ATTR_W-1:0] value,
   input  logic [2:0]        grp,
   input  logic [ADDR_W-1:0] base,
   output logic [LINES*ATTR_W-1:0] attr_o
);
   localparam int MAX_SHIFT = 4;

   logic [2:0]        shift;
   logic [ADDR_W-1:0] keep_mask;
   logic [ADDR_W-1:0] base_key;

   always_comb begin
      shift     = (grp > 3'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : grp;
      keep_mask = ~((ADDR_W'(1) << shift) - ADDR_W'(1));
      base_key  = base & keep_mask;
   end

   generate
      for (genvar p = 0; p < LINES; p++) begin : g_port
         logic              hit;
         logic [ATTR_W-1:0] attr_q;

         assign hit = wr && ((ADDR_W'(p) & keep_mask) == base_key);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   attr_q <= '0;
            else if (hit) attr_q <= value;
         end

         assign attr_o[p*ATTR_W +: ATTR_W] = attr_q;

         // R8: a hit line holds the written value afterwards
         a_r8_group_value: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> (attr_q == $past(value)));
      end
   endgenerate
endmodule

// File: rtl/cfgw_top.sv
`timescale 1ns/1ps
module cfgw_top
   import cfgw_pkg::*;
#(
   parameter int LINES       = 16,
   parameter int ADDR_W      = 9,
   parameter int ATTR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    strap_en,
   input  logic                    mode_wr,
   input  logic [1:0]              mode_wdata,
   input  logic                    cfg_cs,
   input  logic                    cfg_strobe,
   input  logic                    cfg_ps,
   input  logic [1:0]              cfg_op,
   input  logic [ADDR_W-1:0]       cfg_row,
   input  logic [ADDR_W-1:0]       cfg_col,
   output logic [LINES*LINES-1:0]  xbar_map,
   output logic [LINES*ATTR_W-1:0] port_attr,
   output logic [1:0]              mode_state
);
   localparam int GRP_LSB = ATTR_W;

   generate
      if ((2 ** ADDR_W) < LINES) begin : g_bad_addr
         $error("cfgw_top: ADDR_W too narrow for LINES");
      end
      if (ADDR_W < ATTR_W + 3) begin : g_bad_attr
         $error("cfgw_top: ADDR_W must hold attribute value and group code");
      end
   endgenerate

   logic    rise;
   mode_t   mode_q;
   logic    map_wr;
   logic    attr_wr;
   cfg_op_e op_d;

   cfgw_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe_in (cfg_strobe),
      .rise_o    (rise)
   );

   cfgw_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_en   (strap_en),
      .mode_wr    (mode_wr),
      .mode_wdata (mode_wdata),
      .rise       (rise),
      .cs         (cfg_cs),
      .ps         (cfg_ps),
      .op         (cfg_op),
      .mode_o     (mode_q),
      .map_wr_o   (map_wr),
      .attr_wr_o  (attr_wr),
      .op_o       (op_d)
   );

   cfgw_xbar_cells #(.LINES(LINES), .ADDR_W(ADDR_W)) u_xbar (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (map_wr),
      .op    (op_d),
      .row   (cfg_row),
      .col   (cfg_col),
      .map_o (xbar_map)
   );

   cfgw_attr_bank #(.LINES(LINES), .ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_attr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (attr_wr),
      .value  (cfg_row[ATTR_W-1:0]),
      .grp    (cfg_row[GRP_LSB+2:GRP_LSB]),
      .base   (cfg_col),
      .attr_o (port_attr)
   );

   assign mode_state = {mode_q.en, mode_q.pm};

   // R2: an edge seen without chip select touches nothing
   a_r2_cs_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !cfg_cs) |=> ($stable(xbar_map) && $stable(port_attr)));

   // R5: with the enable bit low the state holds
   a_r5_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q.en) |=> ($stable(xbar_map) && $stable(port_attr)));

   // R6: attributes never change while port-mode is low
   a_r6_attr_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q.pm) |=> $stable(port_attr));

   // R7: map and attributes are never written in the same cycle
   a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({map_wr, attr_wr}) <= 1);
endmodule

// File: tb/cfgw_top_tb_top.sv
`timescale 1ns/1ps
module cfgw_top_tb_top;
   localparam int LINES  = 16;
   localparam int ADDR_W = 9;
   localparam int ATTR_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strap_en = 1'b1;
   logic mode_wr = 1'b0;
   logic [1:0] mode_wdata = 2'b00;
   logic cfg_cs = 1'b0;
   logic cfg_strobe = 1'b0;
   logic cfg_ps = 1'b0;
   logic [1:0] cfg_op = 2'b00;
   logic [ADDR_W-1:0] cfg_row = '0;
   logic [ADDR_W-1:0] cfg_col = '0;
   logic [LINES*LINES-1:0] xbar_map;
   logic [LINES*ATTR_W-1:0] port_attr;
   logic [1:0] mode_state;

   always #2.5 clk = ~clk;

   cfgw_top #(.LINES(LINES), .ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .strap_en(strap_en),
      .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .cfg_cs(cfg_cs), .cfg_strobe(cfg_strobe), .cfg_ps(cfg_ps),
      .cfg_op(cfg_op), .cfg_row(cfg_row), .cfg_col(cfg_col),
      .xbar_map(xbar_map), .port_attr(port_attr), .mode_state(mode_state)
   );

   int n_checks = 0;
   int n_fails  = 0;

   logic [LINES*LINES-1:0]  exp_map;
   logic [LINES*ATTR_W-1:0] exp_attr;
   logic [1:0]              exp_mode;

   task automatic check_all(input string tag);
      n_checks += 3;
      if (mode_state !== exp_mode) begin
         n_fails++;
         $display("FAIL %s mode: actual %b expected %b", tag, mode_state, exp_mode);
      end
      if (xbar_map !== exp_map) begin
         n_fails++;
         $display("FAIL %s map: actual %h expected %h", tag, xbar_map, exp_map);
      end
      if (port_attr !== exp_attr) begin
         n_fails++;
         $display("FAIL %s attr: actual %h expected %h", tag, port_attr, exp_attr);
      end
   endtask

   // reference model of one transfer, from the requirements
   task automatic model(input logic cs, input logic ps, input logic [1:0] op,
                        input int row, input int col);
      logic pse;
      int   sh;
      int   msk;
      if (!cs || !exp_mode[1]) return;
      pse = ps & exp_mode[0];
      if (!pse) begin
         if (op == 2'd2) begin
            if (row < LINES)
               for (int c = 0; c < LINES; c++) exp_map[row*LINES + c] = 1'b0;
         end else if (op != 2'd3 && row < LINES && col < LINES) begin
            exp_map[row*LINES + col] = (op == 2'd0);
         end
      end else if (op == 2'd3) begin
         sh  = (row >> ATTR_W) & 7;
         if (sh > 4) sh = 4;
         msk = (1 << sh) - 1;
         for (int p = 0; p < LINES; p++)
            if ((p & ~msk) == (col & ~msk))
               exp_attr[p*ATTR_W +: ATTR_W] = ATTR_W'(row);
      end
   endtask

   task automatic xfer(input string tag, input logic cs, input logic ps,
                       input logic [1:0] op, input int row, input int col);
      @(negedge clk);
      cfg_cs = cs; cfg_ps = ps; cfg_op = op;
      cfg_row = ADDR_W'(row); cfg_col = ADDR_W'(col);
      cfg_strobe = 1'b1;
      repeat (6) @(negedge clk);
      cfg_strobe = 1'b0;
      repeat (3) @(negedge clk);
      model(cs, ps, op, row, col);
      check_all(tag);
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      mode_wr = 1'b1; mode_wdata = m;
      @(negedge clk);
      mode_wr = 1'b0;
      exp_mode = m;
      check_all("R10");
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      rst_n = 1'b0; strap_en = strap;
      repeat (2) @(negedge clk);
      exp_map = '0; exp_attr = '0; exp_mode = {strap, strap};
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic string tag_of(logic cs, logic ps, logic [1:0] op);
      if (!cs) return "R2";
      if (!exp_mode[1]) return "R5";
      if (!exp_mode[0]) return "R6";
      if (ps) return (op == 2'd3) ? "R8" : "R7";
      if (op == 2'd2) return "R4";
      return "R3";
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      do_reset(1'b1);
      // directed corner cases, mode {1,1}
      xfer("R3", 1, 0, 2'd0, 2, 3);
      xfer("R3", 1, 0, 2'd0, 2, 7);
      xfer("R3", 1, 0, 2'd0, 5, 15);
      xfer("R3", 1, 0, 2'd1, 2, 3);
      xfer("R4", 1, 0, 2'd2, 2, 0);
      xfer("R2", 0, 0, 2'd0, 9, 9);
      xfer("R9", 1, 0, 2'd0, 16, 1);
      xfer("R9", 1, 0, 2'd0, 1, 300);
      xfer("R7", 1, 0, 2'd3, 8'h2A, 5);
      xfer("R7", 1, 1, 2'd0, 4, 4);
      xfer("R8", 1, 1, 2'd3, (0 << 4) | 4'hA, 5);
      xfer("R8", 1, 1, 2'd3, (2 << 4) | 4'h3, 9);
      xfer("R8", 1, 1, 2'd3, (1 << 4) | 4'h7, 14);
      xfer("R9", 1, 1, 2'd3, (1 << 4) | 4'h1, 40);
      xfer("R8", 1, 1, 2'd3, (7 << 4) | 4'h6, 3);
      set_mode(2'b10);
      xfer("R6", 1, 1, 2'd3, (0 << 4) | 4'hF, 0);
      xfer("R6", 1, 1, 2'd0, 6, 6);
      set_mode(2'b01);
      xfer("R5", 1, 0, 2'd0, 7, 7);
      set_mode(2'b00);
      xfer("R5", 1, 1, 2'd2, 5, 0);
      set_mode(2'b11);
      // constrained random
      for (int i = 0; i < 300; i++) begin
         logic       cs;
         logic       ps;
         logic [1:0] op;
         int         row;
         int         col;
         if ($urandom % 25 == 0) set_mode(2'($urandom));
         cs  = ($urandom % 8) != 0;
         ps  = 1'($urandom);
         op  = 2'($urandom);
         row = ($urandom % 2 == 0) ? int'($urandom % 20) : int'($urandom % 512);
         col = ($urandom % 6 == 0) ? int'($urandom % 512) : int'($urandom % 20);
         xfer(tag_of(cs, ps, op), cs, ps, op, row, col);
      end
      do_reset(1'b0);
      xfer("R5", 1, 0, 2'd0, 1, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule